// File: doc/BRIEF.md
# Shared-Bus Instruction Fetch Sequencer

This block is an 8-bit datapath slice with its own step sequencer. It brings instruction bytes out of a 256-byte RAM across one shared bus. The instruction pointer is moved forward by the general ALU, not by a separate incrementer. A step counter runs through seven positions. In the first three positions the controller raises one bus-drive enable and one or two capture strobes. Positions four to six are left for an execute stage that is not part of this block, and position seven is an idle turnaround.

The fetch works in three steps. In step one, the pointer drives the bus. The memory address register captures the bus, and the ALU adds a forced constant of one to the bus value and parks the sum in the accumulator. In step two, the RAM drives the byte it has selected and the instruction register captures it. In step three, the accumulator drives the bus and the pointer captures the incremented value. A side port loads the RAM contents before or between runs.

Top module: `fetch_seq_top`

## Requirements
- R1: While reset is low, and at release, `irOut` reads 8'h00 and `stepOut` reads 1. The pointer, address, accumulator and instruction registers are all zero, so the first fetch reads RAM address 8'h00.
- R2: `stepOut` counts 1,2,3,4,5,6,7 and then returns to 1, advancing once per clock. This makes one instruction cycle 7 clocks long.
- R3: On the clock edge that ends step 2, `irOut` takes the RAM byte at the captured address. The new value is visible while `stepOut` is 3.
- R4: Each instruction cycle fetches from one address above the previous cycle. The Nth cycle after reset (counting from 0) loads RAM[N mod 256].
- R5: The pointer wraps from 8'hFF to 8'h00. The cycle after the fetch from 8'hFF fetches from 8'h00.
- R6: In steps 4 to 7 no capture strobe is raised. `irOut` changes only on the edge that ends step 2.
- R7: At most one of the pointer, accumulator and RAM drive enables is active in any step.
- R8: In step 1 the address register captures the pointer and the accumulator captures pointer + 1 (modulo 256). In step 3 the pointer captures the accumulator.
- R9: A clock edge with `preloadWe` high writes `preloadData` into RAM[`preloadAddr`], and later fetches of that address return the byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| preloadWe | input | 1 | RAM preload write strobe |
| preloadAddr | input | 8 | RAM preload address |
| preloadData | input | 8 | RAM preload byte |
| irOut | output | 8 | Instruction register contents |
| stepOut | output | 3 | Current step, 1 to 7 |

## Verification
Every RAM byte is loaded with a distinct value, so a pointer that skips, repeats or fails to wrap shows up at `irOut` in the very next instruction cycle. The bad value is visible by step 3 of the cycle that follows the faulty increment. If the accumulator or the write-back step is damaged, the second fetch already returns the wrong byte. A miscounting step counter shows at `stepOut` within one clock. A stray capture strobe in the idle steps shows as an `irOut` change outside the step 2 edge.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int STEP_N  = 7;
  localparam int STEP_W  = $clog2(STEP_N + 1);

  typedef enum logic [2:0] {
    ALU_ADD = 3'b000,
    ALU_SUB = 3'b001,
    ALU_AND = 3'b010,
    ALU_OR  = 3'b011,
    ALU_XOR = 3'b100,
    ALU_NOT = 3'b101,
    ALU_SHL = 3'b110,
    ALU_SHR = 3'b111
  } aluOp_e;

  typedef struct packed {
    logic   iarEn;
    logic   iarSet;
    logic   marSet;
    logic   irSet;
    logic   accEn;
    logic   accSet;
    logic   ramEn;
    logic   busOne;
    aluOp_e aluOp;
  } strobes_t;
endpackage

// File: rtl/fetch_alu.sv
`timescale 1ns/1ps
module fetch_alu #(
  parameter int W = 8
) (
  input  fetch_pkg::aluOp_e op,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  output logic [W-1:0]      result
);
  import fetch_pkg::*;

  always_comb begin
    unique case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_XOR: result = opA ^ opB;
      ALU_NOT: result = ~opA;
      ALU_SHL: result = opA << 1;
      ALU_SHR: result = opA >> 1;
      default: result = opA + opB;
    endcase
  end
endmodule

// File: rtl/fetch_step_ctrl.sv
`timescale 1ns/1ps
module fetch_step_ctrl #(
  parameter int STEPS = fetch_pkg::STEP_N,
  localparam int SW   = $clog2(STEPS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [SW-1:0]       step,
  output fetch_pkg::strobes_t strb
);
  import fetch_pkg::*;

  localparam logic [SW-1:0] FIRST = SW'(1);
  localparam logic [SW-1:0] LAST  = SW'(STEPS);

  // step counter: 1..STEPS, last step is the idle turnaround
  always_ff @(posedge clk) begin
    if (!rstN)             step <= FIRST;
    else if (step == LAST) step <= FIRST;
    else                   step <= step + SW'(1);
  end

  // one-hot decode of the fetch steps
  logic isStep1, isStep2, isStep3;
  assign isStep1 = (step == SW'(1));
  assign isStep2 = (step == SW'(2));
  assign isStep3 = (step == SW'(3));

  always_comb begin
    strb        = '0;
    strb.aluOp  = ALU_ADD;
    // step 1: pointer onto bus, address and incremented pointer captured
    strb.iarEn  = isStep1;
    strb.marSet = isStep1;
    strb.busOne = isStep1;
    strb.accSet = isStep1;
    // step 2: selected RAM byte onto bus, instruction register captures
    strb.ramEn  = isStep2;
    strb.irSet  = isStep2;
    // step 3: accumulator onto bus, pointer captures
    strb.accEn  = isStep3;
    strb.iarSet = isStep3;
  end
endmodule

// File: rtl/fetch_datapath.sv
`timescale 1ns/1ps
module fetch_datapath #(
  parameter int DW = fetch_pkg::DATA_W,
  parameter int AW = fetch_pkg::ADDR_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetch_pkg::strobes_t strb,
  input  logic                preloadWe,
  input  logic [AW-1:0]       preloadAddr,
  input  logic [DW-1:0]       preloadData,
  output logic [DW-1:0]       irQ,
  output logic [DW-1:0]       iarQ,
  output logic [DW-1:0]       marQ,
  output logic [DW-1:0]       accQ
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] busVal;
  logic [DW-1:0] ramRd;
  logic [DW-1:0] aluB;
  logic [DW-1:0] aluY;

  // byte-wide RAM, combinational read at the captured address
  assign ramRd = mem[marQ[AW-1:0]];

  always_ff @(posedge clk) begin
    if (preloadWe) mem[preloadAddr] <= preloadData;
  end

  // shared bus: enables are mutually exclusive by sequencing
  always_comb begin
    busVal = '0;
    if (strb.iarEn)      busVal = iarQ;
    else if (strb.accEn) busVal = accQ;
    else if (strb.ramEn) busVal = ramRd;
  end

  // operand B is forced to one by the constant injector
  assign aluB = strb.busOne ? DW'(1) : '0;

  fetch_alu #(.W(DW)) alu_i (
    .op     (strb.aluOp),
    .opA    (busVal),
    .opB    (aluB),
    .result (aluY)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iarQ <= '0;
      marQ <= '0;
      irQ  <= '0;
      accQ <= '0;
    end else begin
      if (strb.iarSet) iarQ <= busVal;
      if (strb.marSet) marQ <= busVal;
      if (strb.irSet)  irQ  <= busVal;
      if (strb.accSet) accQ <= aluY;
    end
  end
endmodule

// File: rtl/fetch_seq_top.sv
`timescale 1ns/1ps
module fetch_seq_top (
  input  logic       clk,
  input  logic       rstN,
  input  logic       preloadWe,
  input  logic [7:0] preloadAddr,
  input  logic [7:0] preloadData,
  output logic [7:0] irOut,
  output logic [2:0] stepOut
);
  import fetch_pkg::*;

  strobes_t          strb;
  logic [DATA_W-1:0] iarVal;
  logic [DATA_W-1:0] marVal;
  logic [DATA_W-1:0] accVal;

  fetch_step_ctrl #(.STEPS(STEP_N)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .step (stepOut),
    .strb (strb)
  );

  fetch_datapath #(.DW(DATA_W), .AW(ADDR_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .preloadWe   (preloadWe),
    .preloadAddr (preloadAddr),
    .preloadData (preloadData),
    .irQ         (irOut),
    .iarQ        (iarVal),
    .marQ        (marVal),
    .accQ        (accVal)
  );
endmodule

// File: rtl/fetch_seq_chk.sv
`timescale 1ns/1ps
module fetch_seq_chk (
  input logic                clk,
  input logic                rstN,
  input fetch_pkg::strobes_t strb,
  input logic [2:0]          stepOut,
  input logic [7:0]          irOut,
  input logic [7:0]          iarVal,
  input logic [7:0]          marVal,
  input logic [7:0]          accVal
);
  // R7
  bus_single_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.iarEn, strb.accEn, strb.ramEn}));

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut != 3'd7) |=> (stepOut == $past(stepOut) + 3'd1));

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut == 3'd7) |=> (stepOut == 3'd1));

  // R6
  idle_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut >= 3'd4) |-> !(strb.iarSet || strb.marSet || strb.irSet || strb.accSet));

  // R6
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut != 3'd2) |=> $stable(irOut));

  // R8
  acc_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut == 3'd1) |=> (accVal == 8'($past(iarVal) + 8'd1)));

  // R8
  mar_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut == 3'd1) |=> (marVal == $past(iarVal)));

  // R4
  iar_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepOut == 3'd3) |=> (iarVal == $past(accVal)));
endmodule

bind fetch_seq_top fetch_seq_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .stepOut (stepOut),
  .irOut   (irOut),
  .iarVal  (iarVal),
  .marVal  (marVal),
  .accVal  (accVal)
);

// File: tb/fetch_seq_top_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       preloadWe = 1'b0;
  logic [7:0] preloadAddr = '0;
  logic [7:0] preloadData = '0;
  logic [7:0] irOut;
  logic [2:0] stepOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  fetch_seq_top dut_i (
    .clk(clk), .rstN(rstN), .preloadWe(preloadWe),
    .preloadAddr(preloadAddr), .preloadData(preloadData),
    .irOut(irOut), .stepOut(stepOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R9: load every RAM byte through the preload port
  task automatic preload(input int mul, input int add);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      preloadWe   = 1'b1;
      preloadAddr = 8'(i);
      preloadData = 8'(i * mul + add);
      model[i]    = 8'(i * mul + add);
    end
    @(negedge clk);
    preloadWe = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ir in reset", irOut, 0);
    chk("R1 step in reset", stepOut, 1);
    rstN = 1'b1;
  endtask

  // R1, R2: reset values and the step order over two cycles
  task automatic t_steps();
    apply_reset();
    chk("R1 step at release", stepOut, 1);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      chk("R2 step order", stepOut, ((k + 1) % 7) + 1);
    end
  endtask

  // R3, R4, R5, R6: consecutive fetches with wrap, IR held outside step 2 edge
  task automatic t_fetch_run(input int cycles, input string tag);
    apply_reset();
    for (int n = 0; n < cycles; n++) begin
      repeat (2) @(negedge clk);
      chk("R2 step after capture", stepOut, 3);
      if (n >= 256) chk("R5 wrap fetch", irOut, model[n % 256]);
      else chk({tag, " R3/R4 fetch"}, irOut, model[n % 256]);
      for (int s = 0; s < 5; s++) begin
        @(negedge clk);
        if (n < 3) chk("R6 ir held", irOut, model[n % 256]);
      end
    end
  endtask

  // R9: rewrite one byte between runs, the refetch returns it
  task automatic t_rewrite();
    @(negedge clk);
    rstN = 1'b0;
    preloadWe = 1'b1; preloadAddr = 8'h02; preloadData = 8'hA5;
    model[2] = 8'hA5;
    @(negedge clk);
    preloadWe = 1'b0;
    t_fetch_run(4, "R9");
  endtask

  initial begin
    preload(37, 11);
    t_steps();
    t_fetch_run(258, "pat1");
    preload(91, 200);
    t_fetch_run(10, "pat2 R9");
    t_rewrite();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule